// File: doc/BRIEF.md
# Fuse Shadow Register Bank

This block keeps a readable, register-mapped copy of a one-time-programmable fuse array. When reset is released, a sequencer fetches every fuse word, one at a time and in ascending index order, through a request/response port. Each word is stored in its shadow slot. The busy flag stays high until the last word has landed. Software then reads fuse contents through a plain register port. It may also overwrite a shadow copy, which leaves the fuse itself unchanged. A pulse on the reload input repeats the whole copy, so the shadows match the fuses again after new programming and every software override is lost.

Write permission is decided by lock bits held in the shadow of fuse word 0. A fixed table assigns each range of word indices to one bit of that lock word. When a region's bit is set, writes aimed at that region are silently dropped. The lock bits are taken from whatever currently sits in the shadow of word 0, whether that value came from the fuses or from a software write.

Top module: `fuse_shadow_bank`

## Requirements
- R1: While `rst` (synchronous, active high) is high, and on every cycle after it until the final fuse word has been stored, `busy` reads 1. In reset `reg_rdata` and `reg_err` are 0. `busy` falls only after the response for word NUM_WORDS-1 (default 63) has been taken.
- R2: Shadow word N is mapped at byte offset 0x400 + N*0x10, for N from 0 to 63. A read strobe on `reg_rd` in one cycle puts that word on `reg_rdata` in the next cycle. The value is held until the next read.
- R3: The sequencer has at most one request outstanding. It presents `fuse_req_valid` only while no response is pending. The accepted indices run 0, 1, 2 … 63 with no gap. Word 0 is requested first.
- R4: A software write changes only the shadow copy. A later reload brings back the fuse value.
- R5: Lock table, with lock bits taken from the shadow of word 0: word 0 → bit 4, words 0x01–0x0F → bit 0, 0x10–0x1F → bit 1, 0x20–0x2F → bit 2, 0x30–0x3F → bit 3. A write to a word whose lock bit is 1 is ignored, and `reg_err` stays 0.
- R6: A one-cycle pulse on `reload` while idle makes `busy` read 1 in the next cycle. The reload then copies all words again, which also rewrites the lock word. A pulse on `reload` while busy is ignored: the sequence in progress continues and no second one starts.
- R7: While `busy` is 1, a register write is not performed and `reg_err` reads 1 in the next cycle. A read is still served from the shadow, and `reg_err` stays 0.
- R8: An access whose offset is not a multiple of 0x10, is below 0x400, or is at or above 0x800 is invalid. An invalid read returns 0. Any invalid access sets `reg_err` to 1 in the next cycle. An invalid write changes nothing.
- R9: The 64-bit unit identifier is formed from words 1 (offset 0x410, low half) and 2 (offset 0x420, high half). Both halves return their fuse values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the initial copy |
| reload | input | 1 | One-cycle pulse that requests a fresh copy from the fuses |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, registered, held until the next read |
| reg_err | output | 1 | Error pulse, registered, one cycle after a rejected or invalid access |
| busy | output | 1 | High while a copy sequence is running |
| fuse_req_valid | output | 1 | Fuse read request valid |
| fuse_req_ready | input | 1 | Fuse array accepts the request |
| fuse_req_idx | output | 6 | Fuse word index being requested |
| fuse_rsp_valid | input | 1 | Fuse read data valid |
| fuse_rsp_data | input | 32 | Fuse read data |

## Verification
The bound checker watches the fuse handshake on every cycle. It checks that the first request is word 0, that each later index is one above the previous, that no request appears while a response is pending, and that busy falls only after word 63. It also checks every cycle that reload starts a sequence, that a busy-time write raises the error flag, and that an invalid read returns zero with an error. Some outcomes depend on the stored contents and can only be shown by the bench's scenarios. These are the values loaded into the shadows, software overrides that reload later discards, writes dropped by each lock region, lock bits that come from the fuses versus from software, and the two identifier halves.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_REQ  = 2'd1,
    LD_WAIT = 2'd2
  } ld_state_e;

  // Lock word bits in use and the width of an index into them.
  localparam int LOCK_BITS  = 5;
  localparam int LOCK_IDX_W = $clog2(LOCK_BITS);

  typedef struct packed {
    logic [7:0]            lo;
    logic [7:0]            hi;
    logic [LOCK_IDX_W-1:0] bitpos;
  } region_t;

  localparam int NUM_REGIONS = 5;

  // Word index range -> lock bit that freezes it.
  localparam region_t REGION_MAP [NUM_REGIONS] = '{
    '{lo: 8'h00, hi: 8'h00, bitpos: 3'd4},
    '{lo: 8'h01, hi: 8'h0F, bitpos: 3'd0},
    '{lo: 8'h10, hi: 8'h1F, bitpos: 3'd1},
    '{lo: 8'h20, hi: 8'h2F, bitpos: 3'd2},
    '{lo: 8'h30, hi: 8'h3F, bitpos: 3'd3}
  };

endpackage

// File: rtl/fsb_addr_dec.sv
module fsb_addr_dec #(
  parameter int          ADDR_W      = 12,
  parameter int          IDX_W       = 6,
  parameter int          NUM_WORDS   = 64,
  parameter int unsigned BASE        = 32'h400,
  parameter int          STRIDE_LOG2 = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned SPAN = NUM_WORDS << STRIDE_LOG2;

  logic [ADDR_W-1:0] rel;

  // Aligned, at or above the base, and inside the mapped window.
  always_comb begin
    rel = addr - ADDR_W'(BASE);
    hit = (addr >= ADDR_W'(BASE)) && (rel < ADDR_W'(SPAN)) &&
          (addr[STRIDE_LOG2-1:0] == '0);
    idx = rel[STRIDE_LOG2 +: IDX_W];
  end
endmodule

// File: rtl/fsb_lock_chk.sv
module fsb_lock_chk
  import fsb_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [LOCK_BITS-1:0] lock_word,
  input  logic [IDX_W-1:0]     idx,
  output logic                 locked
);
  logic [NUM_REGIONS-1:0] region_hit;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    assign region_hit[g] = (8'(idx) >= REGION_MAP[g].lo) &&
                           (8'(idx) <= REGION_MAP[g].hi) &&
                           lock_word[REGION_MAP[g].bitpos];
  end

  assign locked = |region_hit;
endmodule

// File: rtl/fsb_loader.sv
module fsb_loader
  import fsb_pkg::*;
#(
  parameter int NUM_WORDS = 64,
  parameter int IDX_W     = 6,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reload,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [IDX_W-1:0]  req_idx,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              we,
  output logic [IDX_W-1:0]  widx,
  output logic [DATA_W-1:0] wdata
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  ld_state_e        state_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LD_REQ;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        LD_IDLE: if (reload) begin
          state_q <= LD_REQ;
          idx_q   <= '0;
        end
        LD_REQ:  if (req_ready) state_q <= LD_WAIT;
        LD_WAIT: if (rsp_valid) begin
          if (idx_q == LAST_IDX) begin
            state_q <= LD_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= LD_REQ;
          end
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end

  assign req_valid = (state_q == LD_REQ);
  assign req_idx   = idx_q;
  assign busy      = (state_q != LD_IDLE);
  assign we        = (state_q == LD_WAIT) && rsp_valid;
  assign widx      = idx_q;
  assign wdata     = rsp_data;
endmodule

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank
  import fsb_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          DATA_W      = 32,
  parameter int          NUM_WORDS   = 64,
  parameter int unsigned BASE        = 32'h400,
  parameter int          STRIDE_LOG2 = 4,
  localparam int         IDX_W       = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reload,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_err,
  output logic              busy,
  output logic              fuse_req_valid,
  input  logic              fuse_req_ready,
  output logic [IDX_W-1:0]  fuse_req_idx,
  input  logic              fuse_rsp_valid,
  input  logic [DATA_W-1:0] fuse_rsp_data
);
  logic              dec_hit;
  logic [IDX_W-1:0]  dec_idx;
  logic              locked;
  logic              ld_we;
  logic [IDX_W-1:0]  ld_idx;
  logic [DATA_W-1:0] ld_data;
  logic              sw_we;
  logic              mem_we;
  logic [IDX_W-1:0]  mem_widx;
  logic [DATA_W-1:0] mem_wdata;
  logic [LOCK_BITS-1:0] lock_q;
  logic [DATA_W-1:0] rd_word_q;
  logic              rd_hit_q;
  logic              err_q;

  logic [DATA_W-1:0] shadow_mem [NUM_WORDS];

  fsb_addr_dec #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_WORDS(NUM_WORDS),
    .BASE(BASE), .STRIDE_LOG2(STRIDE_LOG2)
  ) u_dec (
    .addr(reg_addr), .hit(dec_hit), .idx(dec_idx)
  );

  fsb_lock_chk #(.IDX_W(IDX_W)) u_lock (
    .lock_word(lock_q), .idx(dec_idx), .locked(locked)
  );

  fsb_loader #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ld (
    .clk(clk), .rst(rst), .reload(reload),
    .req_valid(fuse_req_valid), .req_ready(fuse_req_ready), .req_idx(fuse_req_idx),
    .rsp_valid(fuse_rsp_valid), .rsp_data(fuse_rsp_data),
    .busy(busy), .we(ld_we), .widx(ld_idx), .wdata(ld_data)
  );

  // Single write port shared by the sequencer and software.
  always_comb begin
    sw_we     = reg_wr && dec_hit && !busy && !locked;
    mem_we    = ld_we || sw_we;
    mem_widx  = ld_we ? ld_idx  : dec_idx;
    mem_wdata = ld_we ? ld_data : reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (mem_we) shadow_mem[mem_widx] <= mem_wdata;
  end

  always_ff @(posedge clk) begin
    if (reg_rd) rd_word_q <= shadow_mem[dec_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q   <= '0;
      rd_hit_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (mem_we && (mem_widx == '0)) lock_q <= mem_wdata[LOCK_BITS-1:0];
      if (reg_rd) rd_hit_q <= dec_hit;
      err_q <= ((reg_rd || reg_wr) && !dec_hit) || (reg_wr && dec_hit && busy);
    end
  end

  assign reg_rdata = rd_hit_q ? rd_word_q : '0;
  assign reg_err   = err_q;
endmodule

// File: rtl/fsb_checker.sv
module fsb_checker #(
  parameter int          ADDR_W      = 12,
  parameter int          DATA_W      = 32,
  parameter int          NUM_WORDS   = 64,
  parameter int unsigned BASE        = 32'h400,
  parameter int          STRIDE_LOG2 = 4,
  parameter int          IDX_W       = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              reload,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              reg_err,
  input logic              busy,
  input logic              fuse_req_valid,
  input logic              fuse_req_ready,
  input logic [IDX_W-1:0]  fuse_req_idx,
  input logic              fuse_rsp_valid
);
  localparam int unsigned TOP_ADDR = BASE + (NUM_WORDS << STRIDE_LOG2);

  logic             hs;
  logic             started_q;
  logic             pending_q;
  logic [IDX_W-1:0] last_q;
  logic             bad_addr;

  assign hs       = fuse_req_valid && fuse_req_ready;
  assign bad_addr = (reg_addr[STRIDE_LOG2-1:0] != '0) ||
                    (32'(reg_addr) < BASE) || (32'(reg_addr) >= TOP_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      pending_q <= 1'b0;
      last_q    <= '0;
    end else begin
      if (!busy)   started_q <= 1'b0;
      else if (hs) started_q <= 1'b1;
      if (hs) begin
        last_q    <= fuse_req_idx;
        pending_q <= 1'b1;
      end else if (fuse_rsp_valid) begin
        pending_q <= 1'b0;
      end
    end
  end

  // R1: busy ends only after the last word was fetched
  a_r1_done_after_last: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (last_q == IDX_W'(NUM_WORDS - 1)));

  // R1: busy right after reset release
  a_r1_busy_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> busy);

  // R3: sequence starts at word 0
  a_r3_first_zero: assert property (@(posedge clk) disable iff (rst)
    (hs && !started_q) |-> (fuse_req_idx == '0));

  // R3: ascending by one
  a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
    (hs && started_q) |-> (fuse_req_idx == last_q + 1'b1));

  // R3: single outstanding request
  a_r3_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    pending_q |-> !fuse_req_valid);

  // R6: idle reload starts a sequence
  a_r6_reload_starts: assert property (@(posedge clk) disable iff (rst)
    (!busy && reload) |=> busy);

  // R7: write during busy flags an error
  a_r7_busy_write_err: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wr) |=> reg_err);

  // R8: invalid read returns zero with error
  a_r8_bad_read_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && bad_addr) |=> ((reg_rdata == '0) && reg_err));
endmodule

bind fuse_shadow_bank fsb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS),
  .BASE(BASE), .STRIDE_LOG2(STRIDE_LOG2), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .reload(reload), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .reg_err(reg_err), .busy(busy),
  .fuse_req_valid(fuse_req_valid), .fuse_req_ready(fuse_req_ready),
  .fuse_req_idx(fuse_req_idx), .fuse_rsp_valid(fuse_rsp_valid)
);

// File: tb/sim_fuse_shadow_bank.sv
module sim_fuse_shadow_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reload = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic        busy;
  logic        fuse_req_valid;
  logic        fuse_req_ready;
  logic [5:0]  fuse_req_idx;
  logic        fuse_rsp_valid;
  logic [31:0] fuse_rsp_data;

  logic [31:0] fuse_mem [64];
  logic [31:0] exp_sh   [64];
  int checks = 0;
  int fails  = 0;
  int hs_count = 0;
  int order_bad = 0;
  int exp_next = 0;
  bit hs_pend = 0;
  int hs_idx = 0;
  int dly = 0;

  always #5 clk = ~clk;

  fuse_shadow_bank u0 (
    .clk(clk), .rst(rst), .reload(reload), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_err(reg_err), .busy(busy), .fuse_req_valid(fuse_req_valid),
    .fuse_req_ready(fuse_req_ready), .fuse_req_idx(fuse_req_idx),
    .fuse_rsp_valid(fuse_rsp_valid), .fuse_rsp_data(fuse_rsp_data)
  );

  // Behavioural fuse array with random accept and response delays.
  initial begin
    fuse_req_ready = 1'b0;
    fuse_rsp_valid = 1'b0;
    fuse_rsp_data  = '0;
    forever begin
      @(negedge clk);
      fuse_rsp_valid = 1'b0;
      if (hs_pend) begin
        if (dly == 0) begin
          fuse_rsp_valid = 1'b1;
          fuse_rsp_data  = fuse_mem[hs_idx];
          hs_pend = 0;
        end else begin
          dly--;
        end
      end
      fuse_req_ready = !rst && !hs_pend && !fuse_rsp_valid && fuse_req_valid &&
                       ($urandom % 2 == 0);
      if (fuse_req_ready) begin
        hs_pend = 1;
        hs_idx  = int'(fuse_req_idx);
        dly     = int'($urandom % 3);
        hs_count++;
        if (hs_idx != exp_next) order_bad++;
        exp_next = hs_idx + 1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  function automatic int lock_bit_of(input int idx);
    if (idx == 0)  return 4;
    if (idx < 16)  return 0;
    if (idx < 32)  return 1;
    if (idx < 48)  return 2;
    return 3;
  endfunction

  function automatic bit addr_ok(input logic [11:0] a);
    return (a[3:0] == 4'h0) && (a >= 12'h400) && (a < 12'h800);
  endfunction

  function automatic logic [11:0] off_of(input int idx);
    return 12'(32'h400 + idx * 16);
  endfunction

  task automatic access(input bit w, input bit r, input logic [11:0] a,
                        input logic [31:0] d);
    @(negedge clk);
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  // Model of a software write: applies only if valid, idle and unlocked.
  task automatic sw_write(input logic [11:0] a, input logic [31:0] d, input bit was_busy);
    int idx;
    access(1'b1, 1'b0, a, d);
    if (addr_ok(a) && !was_busy) begin
      idx = (int'(a) - 32'h400) / 16;
      if (!exp_sh[0][lock_bit_of(idx)]) exp_sh[idx] = d;
    end
  endtask

  task automatic pulse_reload();
    @(negedge clk); reload = 1'b1;
    @(negedge clk); reload = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 3000) begin @(negedge clk); n++; end
    chk(!busy, "R1 sequence completes", 32'(busy), 32'h0);
    for (int i = 0; i < 64; i++) exp_sh[i] = fuse_mem[i];
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 64; i++) begin
      access(1'b0, 1'b1, off_of(i), '0);
      chk(reg_rdata == exp_sh[i] && !reg_err, req, reg_rdata, exp_sh[i]);
    end
  endtask

  initial begin
    logic [31:0] lo, hi, d;
    logic [11:0] a;
    int idx;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) fuse_mem[i] = $urandom;
    fuse_mem[0] = 32'h0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(reg_rdata == 32'h0, "R1 reset rdata", reg_rdata, 32'h0);
    chk(reg_err == 1'b0, "R1 reset err", 32'(reg_err), 32'h0);
    chk(busy == 1'b1, "R1 busy in reset", 32'(busy), 32'h1);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy after reset", 32'(busy), 32'h1);
    wait_idle();
    chk(hs_count == 64, "R3 request count", 32'(hs_count), 32'd64);
    chk(order_bad == 0, "R3 ascending order", 32'(order_bad), 32'h0);

    // R2: initial contents at strided offsets
    check_all("R2 loaded word");

    // R9: unique identifier halves
    access(1'b0, 1'b1, 12'h410, '0); lo = reg_rdata;
    access(1'b0, 1'b1, 12'h420, '0); hi = reg_rdata;
    chk({hi, lo} == {fuse_mem[2], fuse_mem[1]}, "R9 uid high", hi, fuse_mem[2]);
    chk(lo == fuse_mem[1], "R9 uid low", lo, fuse_mem[1]);

    // R4: random overrides while unlocked (avoid word 0 here)
    for (int k = 0; k < 40; k++) begin
      idx = 1 + int'($urandom % 63);
      d = $urandom;
      sw_write(off_of(idx), d, 1'b0);
      chk(!reg_err, "R4 write accepted", 32'(reg_err), 32'h0);
      access(1'b0, 1'b1, off_of(idx), '0);
      chk(reg_rdata == exp_sh[idx], "R4 override readback", reg_rdata, exp_sh[idx]);
    end

    // R4/R6: reload discards overrides
    order_bad = 0; hs_count = 0; exp_next = 0;
    pulse_reload();
    chk(busy == 1'b1, "R6 reload sets busy", 32'(busy), 32'h1);
    wait_idle();
    chk(hs_count == 64 && order_bad == 0, "R6 reload sequence", 32'(hs_count), 32'd64);
    check_all("R4 fuse value restored");

    // R5: software lock of region 0x10-0x1F (bit 1)
    sw_write(12'h400, 32'h0000_0002, 1'b0);
    d = $urandom;
    sw_write(off_of(21), d, 1'b0);
    chk(!reg_err, "R5 locked write no error", 32'(reg_err), 32'h0);
    access(1'b0, 1'b1, off_of(21), '0);
    chk(reg_rdata == fuse_mem[21], "R5 locked word unchanged", reg_rdata, fuse_mem[21]);
    sw_write(off_of(5), d, 1'b0);
    access(1'b0, 1'b1, off_of(5), '0);
    chk(reg_rdata == d, "R5 unlocked region writes", reg_rdata, d);
    // R5: lock word freezes itself with bit 4
    sw_write(12'h400, 32'h0000_0012, 1'b0);
    sw_write(12'h400, 32'h0000_0000, 1'b0);
    access(1'b0, 1'b1, 12'h400, '0);
    chk(reg_rdata == 32'h12, "R5 lock word self-lock", reg_rdata, 32'h12);

    // R6: reload restores lock word from fuses; lock now from fuse bit 2
    fuse_mem[0] = 32'h0000_0004;
    pulse_reload();
    wait_idle();
    access(1'b0, 1'b1, 12'h400, '0);
    chk(reg_rdata == 32'h4, "R6 lock word reloaded", reg_rdata, 32'h4);
    sw_write(off_of(37), ~fuse_mem[37], 1'b0);
    access(1'b0, 1'b1, off_of(37), '0);
    chk(reg_rdata == fuse_mem[37], "R5 fuse-set lock blocks", reg_rdata, fuse_mem[37]);
    sw_write(off_of(21), ~fuse_mem[21], 1'b0);
    access(1'b0, 1'b1, off_of(21), '0);
    chk(reg_rdata == ~fuse_mem[21], "R5 region 1 now open", reg_rdata, ~fuse_mem[21]);

    // R7: accesses while busy; R6: reload during busy ignored
    order_bad = 0; hs_count = 0; exp_next = 0;
    pulse_reload();
    sw_write(off_of(50), 32'hDEAD_BEEF, 1'b1);
    chk(reg_err == 1'b1, "R7 busy write error", 32'(reg_err), 32'h1);
    access(1'b0, 1'b1, off_of(50), '0);
    chk(reg_err == 1'b0, "R7 busy read no error", 32'(reg_err), 32'h0);
    pulse_reload();
    wait_idle();
    chk(hs_count == 64, "R6 busy reload ignored", 32'(hs_count), 32'd64);
    access(1'b0, 1'b1, off_of(50), '0);
    chk(reg_rdata == fuse_mem[50], "R7 busy write dropped", reg_rdata, fuse_mem[50]);

    // R8: directed bad offsets
    access(1'b0, 1'b1, 12'h404, '0);
    chk(reg_rdata == 0 && reg_err, "R8 misaligned read", reg_rdata, 32'h0);
    access(1'b0, 1'b1, 12'h3F0, '0);
    chk(reg_rdata == 0 && reg_err, "R8 below base", reg_rdata, 32'h0);
    access(1'b0, 1'b1, 12'h800, '0);
    chk(reg_rdata == 0 && reg_err, "R8 above range", reg_rdata, 32'h0);
    sw_write(12'h408, 32'h0, 1'b0);
    chk(reg_err == 1'b1, "R8 bad write error", 32'(reg_err), 32'h1);
    access(1'b0, 1'b1, 12'h400, '0);
    chk(reg_rdata == exp_sh[0], "R8 bad write no effect", reg_rdata, exp_sh[0]);
    access(1'b0, 1'b1, 12'h7F0, '0);
    chk(reg_rdata == exp_sh[63] && !reg_err, "R2 last word offset", reg_rdata, exp_sh[63]);

    // R8/R2: random offsets
    for (int k = 0; k < 60; k++) begin
      a = 12'($urandom);
      if (k % 3 == 0) a[3:0] = 4'h0;
      access(1'b0, 1'b1, a, '0);
      if (addr_ok(a)) begin
        idx = (int'(a) - 32'h400) / 16;
        chk(reg_rdata == exp_sh[idx] && !reg_err, "R2 random read", reg_rdata, exp_sh[idx]);
      end else begin
        chk(reg_rdata == 32'h0 && reg_err, "R8 random bad read", reg_rdata, 32'h0);
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule